// File: doc/BRIEF.md
# Banked Region Tree Child Lookup

This block holds the tree of monitored code regions used by a run-time timing monitor. Each region record carries an entry address, an exit address, the index of its first child and the number of children it has. The children of any region sit at consecutive indices, so a region's first-child index and child count are enough to name all of them.

The table is split into interleaved banks, and every index lives in the bank given by its low bits. Any run of up to one bank-count of consecutive indices therefore touches each bank at most once. This holds from any starting index, including runs that cross from the last bank back to bank 0 or past the end of the table. In one cycle the block reads every child of the region named on its inputs and compares each child's entry address with the current program counter. One clock later it reports whether a child matched, which one, and that child's full record.

A separate write port loads records one per cycle. Building the tree and keeping the stack of active regions are left to the surrounding monitor.

Top module: `region_child_lookup`

## Requirements
- R1: While reset is held and at the first edge after it, every output (hit flag, index and all record fields) is zero.
- R2: A lookup presented before a clock edge shows its result on the outputs right after that edge, and the outputs hold their previous value until that edge.
- R3: A hit is reported when a child at index first+k, for k below the effective child count, has an entry address equal to the PC. The result carries that child's index and its entry, exit, first-child and count fields.
- R4: A child count of zero never produces a hit, even when the record at the first-child index has an entry address equal to the PC.
- R5: Lanes at or beyond the child count are masked. A matching record at index first+count is not reported.
- R6: When several enabled children match the PC, the one with the lowest offset k is reported.
- R7: A run of children that crosses from the last bank to bank 0 (into the next row) is read and compared in the same single cycle.
- R8: A child count above the number of banks (8) is treated as 8. Children at offsets 0 to 7 are searched and offset 8 or more is never reported.
- R9: Child indices are taken modulo the table depth, so a run starting near the end of the table continues at index 0.
- R10: A write stores the 64-bit record at the given index, in bank index mod 8 and row index div 8. A lookup in the same cycle as a write sees the previous record, and lookups from the next cycle on see the new one.
- R11: When no hit is reported, the index and all record fields on the outputs are zero.
- R12: Record layout on the write port: bits 63:40 entry address, bits 39:16 exit address, bits 15:4 first-child index, bits 3:0 child count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the result registers |
| lk_first | input | 12 | First-child index of the region being searched |
| lk_count | input | 4 | Child count of the region being searched |
| lk_pc | input | 24 | Current program counter |
| wr_en | input | 1 | Write strobe for the table |
| wr_idx | input | 12 | Index of the record to write |
| wr_rec | input | 64 | Record to write (layout in R12) |
| hit | output | 1 | A child matched the PC |
| hit_idx | output | 12 | Index of the matching child |
| hit_entry | output | 24 | Entry address of the matching child |
| hit_exit | output | 24 | Exit address of the matching child |
| hit_first | output | 12 | First-child index of the matching child |
| hit_count | output | 4 | Child count of the matching child |

## Verification
The bench builds the block with a table depth of 128 and eight banks. The small depth lets a run starting at index 125 wrap past the table end into index 0, and it keeps a full background load of the table within a few hundred cycles. Keeping all eight lanes exercises the full bank rotation, which covers runs that cross the bank 7 to bank 0 boundary, counts clamped at eight, and lowest-lane priority with matches spread across distinct banks.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 12;
  localparam int CNT_W  = 4;
  localparam int REC_W  = 2 * ADDR_W + IDX_W + CNT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] entry_pc;
    logic [ADDR_W-1:0] exit_pc;
    logic [IDX_W-1:0]  first;
    logic [CNT_W-1:0]  count;
  } region_rec_t;

  // number of lanes a child count enables, clamped to the lane count
  function automatic int unsigned lanes_used(input logic [CNT_W-1:0] cnt,
                                             input int unsigned lanes);
    int unsigned c;
    c = int'(cnt);
    return (c > lanes) ? lanes : c;
  endfunction
endpackage

// File: rtl/rct_bank.sv
module rct_bank
  import rct_pkg::*;
#(
  parameter int ROWS  = 512,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  wr_row,
  input  region_rec_t       wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  output region_rec_t       rd_data
);
  region_rec_t mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wr_row] <= wr_data;
  end

  assign rd_data = mem[rd_row];
endmodule

// File: rtl/rct_lane.sv
module rct_lane
  import rct_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int TIDX_W = 12,
  parameter int K      = 0,
  localparam int BANK_W = $clog2(LANES)
) (
  input  region_rec_t [LANES-1:0] bank_rec,
  input  logic [TIDX_W-1:0]       first_t,
  input  logic [CNT_W-1:0]        count,
  input  logic [ADDR_W-1:0]       pc,
  output logic                    en,
  output logic                    eq,
  output logic [TIDX_W-1:0]       idx,
  output region_rec_t             rec
);
  logic [BANK_W-1:0] bank_sel;

  assign bank_sel = first_t[BANK_W-1:0] + BANK_W'(K);
  assign idx      = first_t + TIDX_W'(K);
  assign rec      = bank_rec[bank_sel];
  assign en       = (K < int'(lanes_used(count, LANES)));
  assign eq       = (rec.entry_pc == pc);
endmodule

// File: rtl/rct_prio.sv
module rct_prio #(
  parameter int LANES = 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] req,
  output logic [LANES-1:0] grant,
  output logic             any,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    grant = '0;
    sel   = '0;
    any   = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        sel = SEL_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/region_child_lookup.sv
module region_child_lookup
  import rct_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int LANES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       lk_first,
  input  logic [3:0]        lk_count,
  input  logic [23:0]       lk_pc,
  input  logic              wr_en,
  input  logic [11:0]       wr_idx,
  input  logic [63:0]       wr_rec,
  output logic              hit,
  output logic [11:0]       hit_idx,
  output logic [23:0]       hit_entry,
  output logic [23:0]       hit_exit,
  output logic [11:0]       hit_first,
  output logic [3:0]        hit_count
);
  localparam int TIDX_W = $clog2(DEPTH);
  localparam int BANK_W = $clog2(LANES);
  localparam int ROWS   = DEPTH / LANES;
  localparam int ROW_W  = TIDX_W - BANK_W;

  logic [TIDX_W-1:0]       first_t;
  logic [TIDX_W-1:0]       wr_t;
  region_rec_t             wr_data;
  region_rec_t [LANES-1:0] bank_rec;
  region_rec_t [LANES-1:0] lane_rec;
  logic [LANES-1:0]        lane_en;
  logic [LANES-1:0]        lane_eq;
  logic [LANES-1:0]        lane_match;
  logic [LANES-1:0]        lane_grant;
  logic [TIDX_W-1:0]       lane_idx [LANES];
  logic                    any_match;
  logic [BANK_W-1:0]       sel_lane;

  assign first_t = lk_first[TIDX_W-1:0];
  assign wr_t    = wr_idx[TIDX_W-1:0];
  assign wr_data = region_rec_t'(wr_rec);

  // each bank serves exactly one lane of any consecutive run
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [BANK_W-1:0] off;
    logic [TIDX_W-1:0] rd_idx;
    logic              we_b;
    assign off    = BANK_W'(b) - first_t[BANK_W-1:0];
    assign rd_idx = first_t + TIDX_W'(off);
    assign we_b   = wr_en && (wr_t[BANK_W-1:0] == BANK_W'(b));
    rct_bank #(.ROWS(ROWS)) u_bank (
      .clk     (clk),
      .we      (we_b),
      .wr_row  (wr_t[TIDX_W-1:BANK_W]),
      .wr_data (wr_data),
      .rd_row  (rd_idx[TIDX_W-1:BANK_W]),
      .rd_data (bank_rec[b])
    );
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rct_lane #(.LANES(LANES), .TIDX_W(TIDX_W), .K(k)) u_lane (
      .bank_rec (bank_rec),
      .first_t  (first_t),
      .count    (lk_count),
      .pc       (lk_pc),
      .en       (lane_en[k]),
      .eq       (lane_eq[k]),
      .idx      (lane_idx[k]),
      .rec      (lane_rec[k])
    );
  end

  assign lane_match = lane_en & lane_eq;

  rct_prio #(.LANES(LANES)) u_prio (
    .req   (lane_match),
    .grant (lane_grant),
    .any   (any_match),
    .sel   (sel_lane)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      hit_entry <= '0;
      hit_exit  <= '0;
      hit_first <= '0;
      hit_count <= '0;
    end else if (any_match) begin
      hit       <= 1'b1;
      hit_idx   <= 12'(lane_idx[sel_lane]);
      hit_entry <= lane_rec[sel_lane].entry_pc;
      hit_exit  <= lane_rec[sel_lane].exit_pc;
      hit_first <= lane_rec[sel_lane].first;
      hit_count <= lane_rec[sel_lane].count;
    end else begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      hit_entry <= '0;
      hit_exit  <= '0;
      hit_first <= '0;
      hit_count <= '0;
    end
  end
endmodule

// File: rtl/rct_checker.sv
module rct_checker
  import rct_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      lk_first,
  input logic [3:0]       lk_count,
  input logic [23:0]      lk_pc,
  input logic             hit,
  input logic [11:0]      hit_idx,
  input logic [23:0]      hit_entry,
  input logic [23:0]      hit_exit,
  input logic [11:0]      hit_first,
  input logic [3:0]       hit_count,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] lane_match,
  input logic [LANES-1:0] lane_grant
);
  localparam int TIDX_W = $clog2(DEPTH);

  logic              pv;
  logic [TIDX_W-1:0] first_d;
  logic [3:0]        count_d;
  logic [23:0]       pc_d;
  logic [LANES-1:0]  match_d;
  logic [TIDX_W-1:0] offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= 1'b0; first_d <= '0; count_d <= '0; pc_d <= '0; match_d <= '0;
    end else begin
      pv <= 1'b1;
      first_d <= lk_first[TIDX_W-1:0];
      count_d <= lk_count;
      pc_d    <= lk_pc;
      match_d <= lane_match;
    end
  end

  assign offs = hit_idx[TIDX_W-1:0] - first_d;

  p_reg_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (hit == (|match_d)));
  p_hit_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && hit) |-> (hit_entry == pc_d));
  p_leaf_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && count_d == 4'd0) |-> !hit);
  p_hit_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && hit) |-> (int'(offs) < int'(lanes_used(count_d, LANES))));
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_grant) && ((lane_grant & ~lane_match) == '0)
    && ((lane_match != '0) == (lane_grant != '0)));
  p_lane_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) == int'(lanes_used(lk_count, LANES)));
  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && hit_entry == '0 && hit_exit == '0
              && hit_first == '0 && hit_count == '0));
endmodule

bind region_child_lookup rct_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_first   (lk_first),
  .lk_count   (lk_count),
  .lk_pc      (lk_pc),
  .hit        (hit),
  .hit_idx    (hit_idx),
  .hit_entry  (hit_entry),
  .hit_exit   (hit_exit),
  .hit_first  (hit_first),
  .hit_count  (hit_count),
  .lane_en    (lane_en),
  .lane_match (lane_match),
  .lane_grant (lane_grant)
);

// File: tb/sim_region_child_lookup.sv
module sim_region_child_lookup;
  localparam int DEPTH = 128;
  localparam int LANES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] lk_first = '0;
  logic [3:0]  lk_count = '0;
  logic [23:0] lk_pc = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_idx = '0;
  logic [63:0] wr_rec = '0;
  logic        hit;
  logic [11:0] hit_idx;
  logic [23:0] hit_entry, hit_exit;
  logic [11:0] hit_first;
  logic [3:0]  hit_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] shadow [DEPTH];

  always #5 clk = ~clk;

  region_child_lookup #(.DEPTH(DEPTH), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_first(lk_first), .lk_count(lk_count),
    .lk_pc(lk_pc), .wr_en(wr_en), .wr_idx(wr_idx), .wr_rec(wr_rec),
    .hit(hit), .hit_idx(hit_idx), .hit_entry(hit_entry), .hit_exit(hit_exit),
    .hit_first(hit_first), .hit_count(hit_count));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [76:0] act, input logic [76:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkrec(input logic [23:0] e, input logic [23:0] x,
                                        input logic [11:0] f, input logic [3:0] c);
    return {e, x, f, c};   // R12 layout
  endfunction

  function automatic logic [76:0] model(input logic [11:0] f, input logic [3:0] c,
                                        input logic [23:0] pc);
    int n;
    n = (c > 8) ? 8 : int'(c);
    for (int k = 0; k < n; k++) begin
      int i;
      i = (int'(f) + k) % DEPTH;
      if (shadow[i][63:40] == pc) return {1'b1, 12'(i), shadow[i]};
    end
    return '0;
  endfunction

  function automatic logic [76:0] observed();
    return {hit, hit_idx, hit_entry, hit_exit, hit_first, hit_count};
  endfunction

  task automatic write_rec(input int idx, input logic [63:0] rec);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 12'(idx); wr_rec = rec;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    shadow[idx % DEPTH] = rec;
  endtask

  task automatic lookup(input logic [11:0] f, input logic [3:0] c,
                        input logic [23:0] pc, input string tag);
    logic [76:0] exp;
    @(negedge clk);
    lk_first = f; lk_count = c; lk_pc = pc;
    exp = model(f, c, pc);
    @(posedge clk);
    @(negedge clk);
    check(observed() == exp, tag, "lookup result", observed(), exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(observed() == '0, "R1", "outputs in reset", observed(), '0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(observed() == '0, "R1", "outputs after reset", observed(), '0);
  endtask

  task automatic t_load;
    for (int i = 0; i < DEPTH; i++)
      write_rec(i, mkrec(24'hA00000 + 24'(i), 24'hB00000 + 24'(i), 12'(i), 4'd0));
  endtask

  task automatic t_basic;
    write_rec(16, mkrec(24'h100010, 24'h100020, 12'd50, 4'd2));
    write_rec(17, mkrec(24'h100030, 24'h100040, 12'd70, 4'd5));
    write_rec(18, mkrec(24'h100050, 24'h100060, 12'd0, 4'd0));
    lookup(12'd16, 4'd3, 24'h100030, "R3");
    check(hit && hit_idx == 12'd17, "R3", "hit on middle child", {hit, hit_idx}, {1'b1, 12'd17});
    check({hit_entry, hit_exit, hit_first, hit_count} == 64'h100030_100040_046_5, "R12",
          "fields of matched record", {hit_entry, hit_exit, hit_first, hit_count},
          64'h100030_100040_046_5);
    // R2: new inputs are not visible before the next edge
    @(negedge clk);
    lk_pc = 24'h123456;
    #2;
    check(hit == 1'b1, "R2", "held before edge", hit, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check(hit == 1'b0, "R2", "updated after edge", hit, 1'b0);
    check(observed() == '0, "R11", "miss clears fields", observed(), '0);
  endtask

  task automatic t_leaf;
    write_rec(24, mkrec(24'h200000, 24'h200004, 12'd0, 4'd0));
    lookup(12'd24, 4'd0, 24'h200000, "R4");
    check(!hit, "R4", "leaf count zero", hit, 1'b0);
  endtask

  task automatic t_mask;
    write_rec(34, mkrec(24'h300000, 24'h300004, 12'd0, 4'd0));
    lookup(12'd32, 4'd2, 24'h300000, "R5");
    check(!hit, "R5", "child beyond count masked", hit, 1'b0);
    lookup(12'd32, 4'd3, 24'h300000, "R5");
    check(hit && hit_idx == 12'd34, "R5", "last enabled child", {hit, hit_idx}, {1'b1, 12'd34});
  endtask

  task automatic t_prio;
    write_rec(81, mkrec(24'h400000, 24'h400100, 12'd1, 4'd1));
    write_rec(84, mkrec(24'h400000, 24'h400200, 12'd2, 4'd2));
    lookup(12'd80, 4'd6, 24'h400000, "R6");
    check(hit && hit_idx == 12'd81 && hit_exit == 24'h400100, "R6", "lowest lane wins",
          {hit, hit_idx, hit_exit}, {1'b1, 12'd81, 24'h400100});
  endtask

  task automatic t_bankwrap;
    write_rec(17, mkrec(24'h500000, 24'h500004, 12'd3, 4'd3));
    lookup(12'd13, 4'd6, 24'h500000, "R7");
    check(hit && hit_idx == 12'd17, "R7", "run across bank 7 to 0", {hit, hit_idx}, {1'b1, 12'd17});
  endtask

  task automatic t_clamp;
    write_rec(47, mkrec(24'h600000, 24'h600004, 12'd0, 4'd0));
    write_rec(48, mkrec(24'h600100, 24'h600104, 12'd0, 4'd0));
    lookup(12'd40, 4'd12, 24'h600000, "R8");
    check(hit && hit_idx == 12'd47, "R8", "count 12 reaches offset 7", {hit, hit_idx}, {1'b1, 12'd47});
    lookup(12'd40, 4'd15, 24'h600100, "R8");
    check(!hit, "R8", "offset 8 never searched", hit, 1'b0);
  endtask

  task automatic t_tablewrap;
    write_rec(1, mkrec(24'h700000, 24'h700004, 12'd9, 4'd1));
    lookup(12'd125, 4'd5, 24'h700000, "R9");
    check(hit && hit_idx == 12'd1, "R9", "run wraps past table end", {hit, hit_idx}, {1'b1, 12'd1});
  endtask

  task automatic t_collide;
    logic [63:0] nrec;
    nrec = mkrec(24'h800000, 24'h800004, 12'd5, 4'd5);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 12'd60; wr_rec = nrec;
    lk_first = 12'd60; lk_count = 4'd1; lk_pc = 24'h800000;
    @(posedge clk);
    @(negedge clk);
    check(!hit, "R10", "same-cycle lookup sees old record", hit, 1'b0);
    wr_en = 1'b0;
    shadow[60] = nrec;
    @(posedge clk);
    @(negedge clk);
    check(hit && hit_idx == 12'd60 && {hit_entry, hit_exit, hit_first, hit_count} == nrec,
          "R10", "written record visible next cycle", observed(), {1'b1, 12'd60, nrec});
    lookup(12'd56, 4'd8, 24'h800000, "R10");
  endtask

  task automatic t_sweep;
    for (int f = 0; f < DEPTH; f += 9) begin
      logic [11:0] tgt;
      tgt = 12'((f + (f % 8)) % DEPTH);
      lookup(12'(f), 4'(f % 11), shadow[tgt][63:40], "R3");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_load();
    t_basic();
    t_leaf();
    t_mask();
    t_prio();
    t_bankwrap();
    t_clamp();
    t_tablewrap();
    t_collide();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule